// File: doc/BRIEF.md
# Barrel Shifter with Carry-Out

This block is the shift stage of a 32-bit processor datapath. It takes a source operand, a shift amount, a shift kind and the current carry flag. It returns the shifted value and the carry that the shift produces. It also returns a negative flag and a zero flag derived from the result, so a flag-setting instruction can use them directly.

The amount comes from a register, and only the low eight bits of that register count. The block handles every amount from 0 to 255 exactly, including the cases of zero, exactly the word width, and more than the word width. An immediate-form select input makes an encoded amount of zero mean a full-width shift for the two right shifts.

The block is purely combinational and has no clock or reset.

Top module: `shift_unit`

## Requirements
- R1: When the effective amount is zero, `res_o` equals `src_i` and `carry_o` equals `carry_i`, for every shift kind.
- R2: Kind 0 (left logical) with amount n from 1 to 31 gives `src_i << n` and carries out source bit 32-n. With n equal to 32 it gives 0 and carries out source bit 0. With n above 32 it gives 0 and carries out 0.
- R3: Kind 1 (right logical) with amount n from 1 to 31 gives `src_i >> n` and carries out source bit n-1. With n equal to 32 it gives 0 and carries out source bit 31. With n above 32 it gives 0 and carries out 0.
- R4: Kind 2 (right arithmetic) with amount n from 1 to 31 gives the sign-extending shift and carries out source bit n-1. With n of 32 or more, every result bit equals source bit 31, and so does the carry-out.
- R5: Kind 3 (rotate right) rotates by the amount modulo 32. For a non-zero amount, the carry-out is result bit 31. This includes non-zero multiples of 32, where the result is the unchanged source and the carry-out is source bit 31.
- R6: Bits 31:8 of `amt_i` have no effect on any output.
- R7: With `imm_i` high, an amount of zero means 32 for kinds 1 and 2. For kinds 0 and 3 it stays a zero amount, with the R1 behaviour.
- R8: `neg_o` equals bit 31 of `res_o`. `zero_o` is high exactly when `res_o` is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_i | input | 32 | Operand to be shifted |
| amt_i | input | 32 | Register holding the shift amount; only bits 7:0 are used |
| kind_i | input | 2 | Shift kind: 0 left logical, 1 right logical, 2 right arithmetic, 3 rotate right |
| imm_i | input | 1 | Immediate form: a zero amount means 32 for kinds 1 and 2 |
| carry_i | input | 1 | Current carry flag, passed through on a zero amount |
| res_o | output | 32 | Shifted result |
| carry_o | output | 1 | Shifter carry-out |
| neg_o | output | 1 | Result bit 31 |
| zero_o | output | 1 | High when the result is zero |

## Verification
All four results depend only on the inputs present at the same time, so each is due in the same cycle as its stimulus, with no register in between. The bench changes the inputs on the falling clock edge. It samples the outputs one nanosecond later, well before the next rising edge, so every sample sees a settled combinational value. The expected values come from a bit-serial reference that shifts one position per loop step. It covers every amount from 0 to 255 for each kind, so the 32 and above-32 boundaries are checked directly.

// File: rtl/shf_pkg.sv
package shf_pkg;
  typedef enum logic [1:0] {
    SHK_LSL = 2'd0,
    SHK_LSR = 2'd1,
    SHK_ASR = 2'd2,
    SHK_ROR = 2'd3
  } shk_e;

  localparam int unsigned SHK_COUNT = 4;
endpackage

// File: rtl/shf_amount.sv
// Normalises the shift amount: keeps only the used low bits and applies the
// immediate zero-means-full-width rule for the right shifts.
module shf_amount
  import shf_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned RW = 32,
  parameter int unsigned AW = 8
) (
  input  logic [RW-1:0] amt_i,
  input  shk_e          kind_i,
  input  logic          imm_i,
  output logic [AW-1:0] eff_o,
  output logic          eff_zero_o,
  output logic          eff_wide_o
);
  localparam logic [AW-1:0] FULL = AW'(DW);

  logic [AW-1:0] low;
  logic          right_kind;

  assign low        = amt_i[AW-1:0];
  assign right_kind = (kind_i == SHK_LSR) || (kind_i == SHK_ASR);

  always_comb begin
    eff_o = low;
    if (imm_i && right_kind && (low == '0)) eff_o = FULL;
  end

  assign eff_zero_o = (eff_o == '0);
  assign eff_wide_o = (eff_o >= FULL);
endmodule

// File: rtl/shf_stage.sv
// One shift kind, selected by parameter; all kinds run side by side.
module shf_stage
  import shf_pkg::*;
#(
  parameter int unsigned DW   = 32,
  parameter int unsigned AW   = 8,
  parameter shk_e        KIND = SHK_LSL
) (
  input  logic [DW-1:0] src_i,
  input  logic [AW-1:0] amt_i,
  input  logic          carry_i,
  output logic [DW-1:0] res_o,
  output logic          carry_o
);
  localparam int unsigned SHW = $clog2(DW);

  function automatic logic [DW:0] f_lsl(logic [DW-1:0] s, logic [AW-1:0] n, logic c);
    logic [DW-1:0] r;
    logic          co;
    if (n == '0) begin
      r = s; co = c;
    end else if (int'(n) > DW) begin
      r = '0; co = 1'b0;
    end else begin
      co = s[SHW'(DW - int'(n))];
      r  = (int'(n) == DW) ? '0 : (s << n);
    end
    return {co, r};
  endfunction

  function automatic logic [DW:0] f_lsr(logic [DW-1:0] s, logic [AW-1:0] n, logic c);
    logic [DW-1:0] r;
    logic          co;
    if (n == '0) begin
      r = s; co = c;
    end else if (int'(n) > DW) begin
      r = '0; co = 1'b0;
    end else begin
      co = s[SHW'(int'(n) - 1)];
      r  = (int'(n) == DW) ? '0 : (s >> n);
    end
    return {co, r};
  endfunction

  function automatic logic [DW:0] f_asr(logic [DW-1:0] s, logic [AW-1:0] n, logic c);
    logic [DW-1:0] r;
    logic          co;
    if (n == '0) begin
      r = s; co = c;
    end else if (int'(n) >= DW) begin
      r = {DW{s[DW-1]}}; co = s[DW-1];
    end else begin
      co = s[SHW'(int'(n) - 1)];
      r  = DW'($signed(s) >>> n);
    end
    return {co, r};
  endfunction

  function automatic logic [DW:0] f_ror(logic [DW-1:0] s, logic [AW-1:0] n, logic c);
    logic [SHW-1:0] k;
    logic [DW-1:0]  r;
    k = n[SHW-1:0];
    r = (s >> k) | (s << (SHW'(0) - k));
    return {(n == '0) ? c : r[DW-1], r};
  endfunction

  generate
    if (KIND == SHK_LSL) begin : g_lsl
      assign {carry_o, res_o} = f_lsl(src_i, amt_i, carry_i);
    end else if (KIND == SHK_LSR) begin : g_lsr
      assign {carry_o, res_o} = f_lsr(src_i, amt_i, carry_i);
    end else if (KIND == SHK_ASR) begin : g_asr
      assign {carry_o, res_o} = f_asr(src_i, amt_i, carry_i);
    end else begin : g_ror
      assign {carry_o, res_o} = f_ror(src_i, amt_i, carry_i);
    end
  endgenerate
endmodule

// File: rtl/shf_flags.sv
module shf_flags #(
  parameter int unsigned DW = 32
) (
  input  logic [DW-1:0] res_i,
  output logic          neg_o,
  output logic          zero_o
);
  assign neg_o  = res_i[DW-1];
  assign zero_o = ~|res_i;
endmodule

// File: rtl/shift_unit.sv
module shift_unit
  import shf_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned RW = 32,
  parameter int unsigned AW = 8
) (
  input  logic [DW-1:0] src_i,
  input  logic [RW-1:0] amt_i,
  input  logic [1:0]    kind_i,
  input  logic          imm_i,
  input  logic          carry_i,
  output logic [DW-1:0] res_o,
  output logic          carry_o,
  output logic          neg_o,
  output logic          zero_o
);
  shk_e          kind;
  logic [AW-1:0] eff_amt;
  logic          amt_zero;
  logic          amt_wide;
  logic [DW-1:0] cand_res [SHK_COUNT];
  logic          cand_cy  [SHK_COUNT];

  assign kind = shk_e'(kind_i);

  shf_amount #(.DW(DW), .RW(RW), .AW(AW)) u_amount (
    .amt_i      (amt_i),
    .kind_i     (kind),
    .imm_i      (imm_i),
    .eff_o      (eff_amt),
    .eff_zero_o (amt_zero),
    .eff_wide_o (amt_wide)
  );

  for (genvar g = 0; g < SHK_COUNT; g++) begin : g_kind
    shf_stage #(.DW(DW), .AW(AW), .KIND(shk_e'(g))) u_stage (
      .src_i   (src_i),
      .amt_i   (eff_amt),
      .carry_i (carry_i),
      .res_o   (cand_res[g]),
      .carry_o (cand_cy[g])
    );
  end

  assign res_o   = cand_res[kind_i];
  assign carry_o = cand_cy[kind_i];

  shf_flags #(.DW(DW)) u_flags (
    .res_i  (res_o),
    .neg_o  (neg_o),
    .zero_o (zero_o)
  );

  always_comb begin
    if (amt_zero) begin
      p_zero_pass_r1: assert (res_o == src_i && carry_o == carry_i);
    end
    if (kind == SHK_LSL && amt_wide) begin
      p_lsl_clear_r2: assert (res_o == '0);
    end
    if (kind == SHK_LSR && amt_wide) begin
      p_lsr_clear_r3: assert (res_o == '0);
    end
    if (kind == SHK_ASR && amt_wide) begin
      p_asr_fill_r4: assert (carry_o == src_i[DW-1] && res_o == {DW{src_i[DW-1]}});
    end
    if (kind == SHK_ROR && !amt_zero) begin
      p_ror_carry_r5: assert (carry_o == res_o[DW-1]);
    end
    if (imm_i && kind == SHK_LSR && amt_i[AW-1:0] == '0) begin
      p_imm_full_r7: assert (res_o == '0 && carry_o == src_i[DW-1]);
    end
    if (zero_o) begin
      p_flag_excl_r8: assert (!neg_o);
    end
  end
endmodule

// File: tb/shift_unit_bench.sv
module shift_unit_bench;
  logic        clk = 1'b0;
  logic [31:0] src = '0;
  logic [31:0] amt = '0;
  logic [1:0]  kind = '0;
  logic        imm = 1'b0;
  logic        cin = 1'b0;
  logic [31:0] res;
  logic        cout, neg, zero;
  int          checks = 0;
  int          fails  = 0;
  bit          done   = 1'b0;

  always #2 clk = ~clk;

  shift_unit u_shift_unit (
    .src_i(src), .amt_i(amt), .kind_i(kind), .imm_i(imm), .carry_i(cin),
    .res_o(res), .carry_o(cout), .neg_o(neg), .zero_o(zero)
  );

  // Bit-serial reference: returns {carry, result}
  function automatic logic [32:0] model(logic [31:0] s, logic [31:0] a, logic [1:0] k,
                                        logic im, logic c);
    int n = int'(a[7:0]);
    if (im && n == 0 && (k == 2'd1 || k == 2'd2)) n = 32;
    if (k == 2'd3) begin
      for (int i = 0; i < n % 32; i++) s = {s[0], s[31:1]};
      if (n != 0) c = s[31];
    end else begin
      for (int i = 0; i < n; i++) begin
        case (k)
          2'd0:    begin c = s[31]; s = s << 1; end
          2'd1:    begin c = s[0];  s = s >> 1; end
          default: begin c = s[0];  s = {s[31], s[31:1]}; end
        endcase
      end
    end
    return {c, s};
  endfunction

  task automatic check(input string tag, input logic [31:0] s, input logic [31:0] a,
                       input logic [1:0] k, input logic im, input logic c);
    logic [32:0] exp;
    logic        en, ez;
    @(negedge clk);
    src = s; amt = a; kind = k; imm = im; cin = c;
    #1;
    exp = model(s, a, k, im, c);
    en  = exp[31];
    ez  = (exp[31:0] == 32'd0);
    checks++;
    if (res !== exp[31:0] || cout !== exp[32] || neg !== en || zero !== ez) begin
      fails++;
      $display("FAIL %s src=%h amt=%h kind=%0d imm=%0b cin=%0b: got res=%h c=%0b n=%0b z=%0b exp res=%h c=%0b n=%0b z=%0b",
               tag, s, a, k, im, c, res, cout, neg, zero, exp[31:0], exp[32], en, ez);
    end
  endtask

  task automatic t_initial;
    check("R1 initial zero inputs", 32'h0, 32'h0, 2'd0, 1'b0, 1'b0);
  endtask

  task automatic t_zero_amount;
    for (int k = 0; k < 4; k++) begin
      check("R1", 32'hDEAD_BEEF, 32'h0, 2'(k), 1'b0, 1'b1);
      check("R1", 32'h1234_5678, 32'h0, 2'(k), 1'b0, 1'b0);
    end
  endtask

  task automatic t_sweep(input int k, input string tag);
    for (int n = 0; n < 256; n++) begin
      check(tag, 32'h8000_0001, 32'(n), 2'(k), 1'b0, 1'b1);
      check(tag, 32'h7F3C_A5E1, 32'(n), 2'(k), 1'b0, 1'b0);
    end
  endtask

  task automatic t_edges;
    check("R2 lsl 32", 32'h0000_0001, 32'd32, 2'd0, 1'b0, 1'b0);
    check("R2 lsl 33", 32'hFFFF_FFFF, 32'd33, 2'd0, 1'b0, 1'b1);
    check("R3 lsr 32", 32'h8000_0000, 32'd32, 2'd1, 1'b0, 1'b0);
    check("R3 lsr 33", 32'hFFFF_FFFF, 32'd33, 2'd1, 1'b0, 1'b1);
    check("R4 asr 200", 32'h8000_0000, 32'd200, 2'd2, 1'b0, 1'b0);
    check("R4 asr 40 pos", 32'h7FFF_FFFF, 32'd40, 2'd2, 1'b0, 1'b1);
    check("R5 ror 64", 32'h8000_0002, 32'd64, 2'd3, 1'b0, 1'b0);
    check("R5 ror 32", 32'h0000_0002, 32'd32, 2'd3, 1'b0, 1'b1);
  endtask

  task automatic t_upper_bits;
    check("R6", 32'hCAFE_F00D, 32'h0000_0100, 2'd0, 1'b0, 1'b1);
    check("R6", 32'hCAFE_F00D, 32'hFFFF_FF04, 2'd1, 1'b0, 1'b0);
    check("R6", 32'hCAFE_F00D, 32'h8000_0021, 2'd2, 1'b0, 1'b0);
    check("R6", 32'hCAFE_F00D, 32'h1234_5603, 2'd3, 1'b0, 1'b0);
  endtask

  task automatic t_immediate;
    check("R7 lsr imm0", 32'h8000_0000, 32'd0, 2'd1, 1'b1, 1'b0);
    check("R7 asr imm0", 32'h9000_0000, 32'd0, 2'd2, 1'b1, 1'b0);
    check("R7 asr imm0 pos", 32'h4000_0001, 32'd0, 2'd2, 1'b1, 1'b1);
    check("R7 lsl imm0", 32'hA5A5_A5A5, 32'd0, 2'd0, 1'b1, 1'b1);
    check("R7 ror imm0", 32'hA5A5_A5A5, 32'd0, 2'd3, 1'b1, 1'b0);
    check("R7 lsr imm5", 32'hFFFF_FFF0, 32'd5, 2'd1, 1'b1, 1'b0);
  endtask

  task automatic t_flags;
    check("R8 zero", 32'h0000_0010, 32'd5, 2'd1, 1'b0, 1'b0);
    check("R8 neg", 32'h0000_0001, 32'd31, 2'd0, 1'b0, 1'b0);
    check("R8 both clear", 32'h0000_0100, 32'd4, 2'd1, 1'b0, 1'b1);
  endtask

  initial begin
    t_initial();
    t_zero_amount();
    t_sweep(0, "R2 sweep");
    t_sweep(1, "R3 sweep");
    t_sweep(2, "R4 sweep");
    t_sweep(3, "R5 sweep");
    t_edges();
    t_upper_bits();
    t_immediate();
    t_flags();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, got hung exp done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule